// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block holds a synchronous bus master and a memory-side slave. They share one set of lines, `ad_bus`, that carries an address first and data afterwards. A command port hands the master one operation at a time. The master then sequences the address and data phases on the shared lines.

The operations are single read, single write, read-modify-write, read-after-write, and incrementing block read or block write. The modify step of read-modify-write is an XOR of the old word with the command data. Each sub-transfer of a locked pair gets its own address phase. A block gets one address phase followed by several data phases.

The slave latches the address on the address strobe and keeps an internal pointer that steps after every data phase. It serves a small register-file memory. Its read latency is set per transfer by `rd_wait`. Each side has an explicit output enable that models who owns the lines in a given cycle.

Top module: `admux_bus_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `ad_valid`, `m_oe`, `s_oe`, `lock`, `done` and `rd_valid` are 0. All memory words read as 0.
- R2: An accepted command produces an address phase in the next cycle. In that cycle `ad_valid` and `m_oe` are high and `ad_bus` carries `cmd_addr`, zero-extended. Every address phase of one command carries that same address.
- R3: In a read data phase the slave drives `ad_bus` (`s_oe`=1) exactly `rd_wait`+2 cycles after the previous address phase or previous read data phase. The cycles in between are a wait with neither side driving.
- R4: `cmd_op` encodings are 0 read, 1 write, 2 read-modify-write, 3 read-after-write, 4 block read, 5 block write. A write stores `cmd_wdata` at `cmd_addr`, and a later read returns it.
- R5: Read-modify-write reads the addressed word and returns the old value on `rd_data`. It then immediately writes old XOR `cmd_wdata` to the same address.
- R6: Read-after-write writes `cmd_wdata` and then immediately reads the same address, returning `cmd_wdata`.
- R7: A block read uses a single address phase and returns `cmd_count`+1 words. The words come from consecutive addresses starting at `cmd_addr` and wrapping modulo the memory depth.
- R8: A block write uses a single address phase and writes `cmd_wdata`+i to address `cmd_addr`+i (modulo depth) for i = 0..`cmd_count`.
- R9: `m_oe` and `s_oe` are never high in the same cycle.
- R10: `lock` is high from the first address phase through the `done` cycle of a read-modify-write or read-after-write. It is low for all other operations. `cmd_ready` stays low from acceptance until the cycle after `done`.
- R11: `done` is a single-cycle pulse, one cycle after the last data phase. Each read word appears on `rd_data` with `rd_valid` one cycle after the slave drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | AW | Start address |
| cmd_wdata | input | DW | Write data / XOR mask / block base value |
| cmd_count | input | CW | Block length minus one |
| cmd_ready | output | 1 | Master idle, command accepted when valid |
| rd_wait | input | 2 | Extra slave read wait cycles, latched at address phase |
| ad_bus | output | DW | Shared address/data lines |
| ad_valid | output | 1 | Address strobe |
| bus_rd | output | 1 | Read data phase in progress |
| bus_wr | output | 1 | Write data phase |
| m_oe | output | 1 | Master drives the lines |
| s_oe | output | 1 | Slave drives the lines |
| lock | output | 1 | Indivisible sequence in progress |
| done | output | 1 | Command complete pulse |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |

## Verification
The address phase is due one cycle after acceptance. Each slave read drive is due `rd_wait`+2 cycles after the previous address or read phase. `rd_valid` follows a read drive by one cycle, and `done` follows the last data phase by one cycle. The bench samples every cycle at the falling edge and times each slave drive against the cycle of the preceding phase. It compares every address, write word and read word, in order, with queues computed from a bench memory model. A cycle after `done`, it checks that the interface has returned to idle.

// File: rtl/admux_bus_ctrl.sv
module admux_bus_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [CW-1:0] cmd_count,
  output logic          cmd_ready,
  input  logic [1:0]    rd_wait,
  output logic [DW-1:0] ad_bus,
  output logic          ad_valid,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          m_oe,
  output logic          s_oe,
  output logic          lock,
  output logic          done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [2:0] OP_WR = 3'd1, OP_RMW = 3'd2, OP_RAW = 3'd3,
                         OP_BRD = 3'd4, OP_BWR = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WDAT, S_RWAIT, S_DONE} st_t;

  st_t           st;
  logic [2:0]    op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, wbuf, m_drv;
  logic [CW-1:0] left;
  logic          step, pair, ph_wr, last_item;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [2:0]    wc;
  logic [1:0]    wq;
  logic          s_rdy;

  assign pair      = (op == OP_RMW) || (op == OP_RAW);
  assign ph_wr     = (op == OP_WR) || (op == OP_BWR) ||
                     ((op == OP_RMW) && step) || ((op == OP_RAW) && !step);
  assign last_item = (left == '0);

  assign cmd_ready = (st == S_IDLE);
  assign ad_valid  = (st == S_ADDR);
  assign bus_wr    = (st == S_WDAT);
  assign bus_rd    = (st == S_RWAIT);
  assign done      = (st == S_DONE);
  assign m_oe      = ad_valid || bus_wr;
  assign lock      = pair && (st != S_IDLE);
  assign m_drv     = ad_valid ? DW'(addr) : ((op == OP_RMW) ? wbuf : wd);

  assign s_rdy     = bus_rd && (wc == ({1'b0, wq} + 3'd1));
  assign s_oe      = s_rdy;
  assign ad_bus    = m_oe ? m_drv : (s_oe ? mem[ptr] : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op       <= '0;
      addr     <= '0;
      wd       <= '0;
      wbuf     <= '0;
      left     <= '0;
      step     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op   <= cmd_op;
          addr <= cmd_addr;
          wd   <= cmd_wdata;
          left <= (cmd_op == OP_BRD || cmd_op == OP_BWR) ? cmd_count : '0;
          step <= 1'b0;
          st   <= S_ADDR;
        end
        S_ADDR: st <= ph_wr ? S_WDAT : S_RWAIT;
        S_WDAT: begin
          if (op == OP_BWR) wd <= wd + 1'b1;
          if (!last_item) left <= left - 1'b1;
          else if (pair && !step) begin
            step <= 1'b1;
            st   <= S_ADDR;
          end else st <= S_DONE;
        end
        S_RWAIT: if (s_rdy) begin
          rd_valid <= 1'b1;
          rd_data  <= ad_bus;
          wbuf     <= ad_bus ^ wd;
          if (!last_item) left <= left - 1'b1;
          else if (pair && !step) begin
            step <= 1'b1;
            st   <= S_ADDR;
          end else st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      wc  <= '0;
      wq  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ad_valid) begin
      ptr <= ad_bus[AW-1:0];
      wq  <= rd_wait;
      wc  <= '0;
    end else if (bus_wr) begin
      mem[ptr] <= ad_bus;
      ptr      <= ptr + 1'b1;
    end else if (bus_rd) begin
      if (s_rdy) begin
        ptr <= ptr + 1'b1;
        wc  <= '0;
      end else wc <= wc + 1'b1;
    end
  end
endmodule

module admux_bus_sva (
  input logic clk,
  input logic rst_n,
  input logic ad_valid,
  input logic m_oe,
  input logic s_oe,
  input logic lock,
  input logic done,
  input logic cmd_ready
);
  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n) !(m_oe && s_oe)); // R9
  AST_ADDR_OWNER:    assert property (@(posedge clk) disable iff (!rst_n) ad_valid |-> m_oe && !s_oe); // R2
  AST_READ_WAIT:     assert property (@(posedge clk) disable iff (!rst_n) s_oe |-> !$past(ad_valid)); // R3
  AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_LOCK_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(lock) |-> $past(done)); // R10
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !lock && !m_oe && !s_oe); // R10
endmodule

bind admux_bus_ctrl admux_bus_sva chk_i (
  .clk(clk), .rst_n(rst_n), .ad_valid(ad_valid), .m_oe(m_oe), .s_oe(s_oe),
  .lock(lock), .done(done), .cmd_ready(cmd_ready)
);

// File: tb/admux_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module admux_bus_ctrl_tb_top;
  localparam int DW = 16, DEPTH = 16, CW = 3, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [CW-1:0] cmd_count = '0;
  logic [1:0] rd_wait = '0;
  logic cmd_ready, ad_valid, bus_rd, bus_wr, m_oe, s_oe, lock, done, rd_valid;
  logic [DW-1:0] ad_bus, rd_data;

  int vectors = 0, fails = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #4 clk = ~clk;

  admux_bus_ctrl #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .cmd_ready(cmd_ready), .rd_wait(rd_wait), .ad_bus(ad_bus),
    .ad_valid(ad_valid), .bus_rd(bus_rd), .bus_wr(bus_wr), .m_oe(m_oe),
    .s_oe(s_oe), .lock(lock), .done(done), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input int i);
    return AW'(a + i);
  endfunction

  function automatic logic [DW-1:0] rmw_val(input logic [DW-1:0] old, input logic [DW-1:0] m);
    return old ^ m;
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] w, input logic [CW-1:0] n,
                        input logic [1:0] wt);
    logic [DW-1:0] er [16];
    logic [DW-1:0] ew [16];
    int ner = 0, new_ = 0, nap_exp, nap = 0, nrd = 0, nwr = 0;
    int cyc = 0, last = 0, bad_addr = 0, bad_gap = 0, bad_lock = 0;
    int bad_rd = 0, bad_wr = 0, bad_rdy = 0, last_gap = 0;
    bit exp_lock, fin = 0;
    case (op)
      3'd1: begin ew[0] = w; new_ = 1; mdl[a] = w; end
      3'd2: begin er[0] = mdl[a]; ew[0] = rmw_val(mdl[a], w); ner = 1; new_ = 1; mdl[a] = ew[0]; end
      3'd3: begin ew[0] = w; er[0] = w; ner = 1; new_ = 1; mdl[a] = w; end
      3'd4: for (int i = 0; i <= int'(n); i++) begin er[i] = mdl[nxt(a, i)]; ner++; end
      3'd5: for (int i = 0; i <= int'(n); i++) begin ew[i] = w + DW'(i); mdl[nxt(a, i)] = ew[i]; new_++; end
      default: begin er[0] = mdl[a]; ner = 1; end
    endcase
    exp_lock = (op == 3'd2) || (op == 3'd3);
    nap_exp = exp_lock ? 2 : 1;

    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = w; cmd_count = n; rd_wait = wt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!fin && cyc < 200) begin
      if (ad_valid) begin
        nap++; last = cyc;
        if (ad_bus != DW'(a)) bad_addr++;
      end
      if (bus_wr) begin
        if (nwr < new_ && ad_bus != ew[nwr]) bad_wr++;
        nwr++;
      end
      if (s_oe) begin
        if (cyc - last != int'(wt) + 2) begin bad_gap++; last_gap = cyc - last; end
        last = cyc;
      end
      if (rd_valid) begin
        if (nrd < ner && rd_data != er[nrd]) bad_rd++;
        nrd++;
      end
      if (lock != exp_lock) bad_lock++;
      if (cmd_ready) bad_rdy++;
      if (done) fin = 1;
      else begin cyc++; @(negedge clk); end
    end
    chk(fin, "watchdog", cyc, 0);
    chk(bad_addr == 0 && nap == nap_exp, "R2 address phases", nap, nap_exp);
    chk(bad_gap == 0, "R3 read wait", last_gap, int'(wt) + 2);
    chk(nwr == new_ && bad_wr == 0, (op == 3'd5) ? "R8 block write" : "R4/R5/R6 write data", nwr, new_);
    chk(nrd == ner && bad_rd == 0, (op == 3'd4) ? "R7 block read" : "R4/R5/R6 read data", bad_rd, 0);
    chk(bad_lock == 0 && bad_rdy == 0, "R10 lock/ready", bad_lock + bad_rdy, 0);
    @(negedge clk);
    chk(!done && cmd_ready && !lock && !rd_valid, "R11 done pulse", done, 0);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !ad_valid && !m_oe && !s_oe && !lock && !done && !rd_valid,
        "R1 reset outputs", {cmd_ready, ad_valid, m_oe, s_oe, lock, done, rd_valid}, 64);
    rst_n = 1'b1;
    run_op(3'd0, 4'd7, 16'h0, 3'd0, 2'd0);        // R1 memory clear
    run_op(3'd1, 4'd15, 16'hBEEF, 3'd0, 2'd0);    // R4
    run_op(3'd0, 4'd15, 16'h0, 3'd0, 2'd3);       // R3 max wait
    run_op(3'd2, 4'd15, 16'h00FF, 3'd0, 2'd1);    // R5
    run_op(3'd3, 4'd3, 16'h1234, 3'd0, 2'd2);     // R6
    run_op(3'd5, 4'd14, 16'hFFFE, 3'd7, 2'd0);    // R8 wrap
    run_op(3'd4, 4'd13, 16'h0, 3'd7, 2'd3);       // R7 wrap
    run_op(3'd4, 4'd0, 16'h0, 3'd0, 2'd0);        // R7 single item
    for (int k = 0; k < 300; k++)
      run_op(3'($urandom_range(0, 5)), 4'($urandom), 16'($urandom),
             3'($urandom), 2'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule